// File: doc/BRIEF.md
# Idle-Gated MAC Software Reset Controller

This block holds the software reset control of an Ethernet MAC. Software writes a 1 to bit 0 of a single 32-bit control word to ask for a reset of the MAC logic. The block does not apply the reset straight away. It latches the request and keeps it until the receive DMA engine and the transmit DMA engine both report idle. This ensures that no bus transfer is cut off halfway, which could leave the configuration bus hung.

When both engines are idle and a request is latched, the block issues a one-cycle reset pulse to the MAC and drops the request in the same cycle. Software learns the outcome by reading the same bit. It reads 1 while the reset is still waiting and 0 once the reset has been carried out. The block decodes a single word address. Every other address reads as zero and ignores writes.

Top module: `mac_swreset_ctrl`

## Requirements
- R1: After power-on reset the request flag is clear, `mac_rst_pulse` is low and `reg_rdata` is zero.
- R2: A write (`reg_valid`=1, `reg_write`=1) to word address `REG_ADDR` with data bit 0 set latches a reset request. A read of `REG_ADDR` returns 1 in bit 0 while the request is latched.
- R3: Bits 31 to 1 of read data are always zero. A read of any other address returns zero. A write to any other address has no effect.
- R4: `mac_rst_pulse` is never high while `rx_idle` or `tx_idle` is low.
- R5: `mac_rst_pulse` is high in exactly the cycles in which a request is latched and both idle inputs are high. The request clears at that clock edge, so later reads return 0 in bit 0.
- R6: A write to `REG_ADDR` with data bit 0 clear has no effect. A latched request cannot be cancelled by software.
- R7: A write of 1 while a request is latched, or in the cycle the pulse is issued, joins that request. It never produces a second pulse.
- R8: Read data shows the flag value from the cycle of the read access. It appears on `reg_rdata` one clock edge after that access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reg_valid | input | 1 | Register access strobe, one access per cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address of the access |
| reg_wdata | input | DATA_W | Write data; only bit 0 is used |
| reg_rdata | output | DATA_W | Read data, bit 0 = request still pending |
| rx_idle | input | 1 | Receive DMA engine reports idle |
| tx_idle | input | 1 | Transmit DMA engine reports idle |
| mac_rst_pulse | output | 1 | One-cycle active-high reset to the MAC logic |

## Verification
The reset pulse is combinational from the registered request flag and the two idle inputs. The bench therefore samples it 1 ns after it drives the inputs at the falling edge, within the same cycle. A write that sets the flag acts at the next rising edge, so the earliest pulse comes one cycle after the write. Read data is loaded at the rising edge that ends the read cycle and is compared at the next falling edge. The reference model updates its flag only after that edge, so each comparison uses the value from the cycle it belongs to.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

   // Decoded view of one register access cycle
   typedef struct packed {
      logic set_req;   // write of 1 to the control word
      logic rd_hit;    // read of the control word
      logic rd_any;    // any read
   } swrst_access_t;

endpackage

// File: rtl/swrst_regif.sv
module swrst_regif
   import swrst_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 32,
   parameter logic [63:0] REG_ADDR = 64'h4,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              pending,
   output swrst_access_t     acc,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = REG_ADDR[ADDR_W-1:0];
   localparam int                PAD_W    = DATA_W - 1;

   logic              addr_hit;
   logic [DATA_W-1:0] status_word;

   assign addr_hit    = (acc_addr == HIT_ADDR);
   assign status_word = {{PAD_W{1'b0}}, pending};

   always_comb begin
      acc.set_req = acc_valid &  acc_write & addr_hit & acc_wdata[0];
      acc.rd_hit  = acc_valid & ~acc_write & addr_hit;
      acc.rd_any  = acc_valid & ~acc_write;
   end

   generate
      if (RD_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata <= '0;
            end else if (acc.rd_any) begin
               rdata <= acc.rd_hit ? status_word : '0;
            end
         end
      end else begin : g_rd_comb
         always_comb begin
            rdata = acc.rd_hit ? status_word : '0;
         end
      end
   endgenerate

   // R3
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:1] == '0);

endmodule

// File: rtl/swrst_gate.sv
module swrst_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic rx_idle,
   input  logic tx_idle,
   output logic pending,
   output logic fire
);

   logic pending_q;
   logic both_idle;

   assign both_idle = rx_idle & tx_idle;
   assign fire      = pending_q & both_idle;
   assign pending   = pending_q;

   // A request raised in the firing cycle is covered by that pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
      end else begin
         pending_q <= (pending_q | set_req) & ~fire;
      end
   end

   // R2
   set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req && !pending_q) |=> pending_q);

   // R5
   fire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !pending_q);

   // R6
   pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !(rx_idle && tx_idle)) |=> pending_q);

endmodule

// File: rtl/mac_swreset_ctrl.sv
module mac_swreset_ctrl
   import swrst_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 32,
   parameter logic [63:0] REG_ADDR = 64'h4,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              rx_idle,
   input  logic              tx_idle,
   output logic              mac_rst_pulse
);

   localparam longint ADDR_SPAN = longint'(1) << ADDR_W;

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("mac_swreset_ctrl: DATA_W must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("mac_swreset_ctrl: ADDR_W must lie in 1..32");
      end
      if (REG_ADDR >= 64'(ADDR_SPAN)) begin : g_bad_reg_addr
         $error("mac_swreset_ctrl: REG_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   swrst_access_t acc;
   logic          pending;
   logic          fire;

   swrst_regif #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR),
      .RD_REG   (RD_REG)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (reg_valid),
      .acc_write (reg_write),
      .acc_addr  (reg_addr),
      .acc_wdata (reg_wdata),
      .pending   (pending),
      .acc       (acc),
      .rdata     (reg_rdata)
   );

   swrst_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (acc.set_req),
      .rx_idle (rx_idle),
      .tx_idle (tx_idle),
      .pending (pending),
      .fire    (fire)
   );

   assign mac_rst_pulse = fire;

   // R4
   pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mac_rst_pulse |-> (rx_idle && tx_idle));

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mac_rst_pulse |=> !mac_rst_pulse);

endmodule

// File: tb/mac_swreset_ctrl_tb.sv
`timescale 1ns/1ps
module mac_swreset_ctrl_tb;

   localparam int          ADDR_W   = 8;
   localparam int          DATA_W   = 32;
   localparam logic [63:0] REG_ADDR = 64'h4;
   localparam logic [ADDR_W-1:0] RA = REG_ADDR[ADDR_W-1:0];

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_valid = 1'b0;
   logic              reg_write = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              rx_idle = 1'b0;
   logic              tx_idle = 1'b0;
   logic              mac_rst_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   int n_pulses = 0;
   bit finished = 1'b0;

   logic              exp_pending = 1'b0;
   logic [DATA_W-1:0] exp_rdata = '0;

   always #2 clk = ~clk;   // 250 MHz

   mac_swreset_ctrl #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .REG_ADDR (REG_ADDR), .RD_REG (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .reg_valid (reg_valid), .reg_write (reg_write),
      .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .rx_idle (rx_idle), .tx_idle (tx_idle), .mac_rst_pulse (mac_rst_pulse)
   );

   function automatic logic model_fire(logic p, logic rx, logic tx);
      return p & rx & tx;
   endfunction

   function automatic logic model_set(logic v, logic w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
      return v & w & (a == RA) & d[0];
   endfunction

   function automatic logic [DATA_W-1:0] model_read(logic p, logic [ADDR_W-1:0] a);
      return (a == RA) ? {{(DATA_W-1){1'b0}}, p} : '0;
   endfunction

   task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // One bus cycle: check previous read result, drive, check pulse, advance model
   task automatic step(logic v, logic w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                       logic rx, logic tx);
      logic f;
      @(negedge clk);
      check("R8/R2/R3 read data", reg_rdata, exp_rdata);
      reg_valid = v; reg_write = w; reg_addr = a; reg_wdata = d;
      rx_idle = rx;  tx_idle = tx;
      #1;
      f = model_fire(exp_pending, rx, tx);
      check("R4/R5 reset pulse", {31'b0, mac_rst_pulse}, {31'b0, f});
      if (mac_rst_pulse === 1'b1) n_pulses++;
      @(posedge clk);
      if (v && !w) exp_rdata = model_read(exp_pending, a);
      exp_pending = (exp_pending | model_set(v, w, a, d)) & ~f;
   endtask

   task automatic rd(logic rx, logic tx);
      step(1'b1, 1'b0, RA, '0, rx, tx);
   endtask

   task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic rx, logic tx);
      step(1'b1, 1'b1, a, d, rx, tx);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int p0;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      #1;
      // R1: state during and straight after reset
      check("R1 rdata in reset", reg_rdata, '0);
      check("R1 pulse in reset", {31'b0, mac_rst_pulse}, '0);
      @(negedge clk);
      rst_n = 1'b1;

      rd(1'b1, 1'b1);                     // R1 flag reads 0
      wr(RA, 32'h1, 1'b0, 1'b0);          // R2 request
      rd(1'b0, 1'b0);                     // R2 reads 1
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0, '0, i[0], ~i[0]);  // R4 held off
      wr(RA, 32'h0, 1'b0, 1'b1);          // R6 write 0 ignored
      rd(1'b1, 1'b0);
      p0 = n_pulses;
      wr(RA, 32'h1, 1'b0, 1'b1);          // R7 extra writes join
      wr(RA, 32'hFFFF_FFFF, 1'b1, 1'b0);
      step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1);   // R5 pulse here
      step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1);
      step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1);
      check("R7 one pulse per request", n_pulses - p0, 1);
      rd(1'b1, 1'b1);                     // R5 reads 0 afterwards

      // R7: write of 1 in the firing cycle
      wr(RA, 32'h1, 1'b0, 1'b0);
      p0 = n_pulses;
      wr(RA, 32'h1, 1'b1, 1'b1);
      step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1);
      step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1);
      check("R7 firing-cycle write absorbed", n_pulses - p0, 1);

      // R3: other address and reserved bits
      wr(RA + 8'd1, 32'h1, 1'b0, 1'b0);
      wr(RA, 32'hFFFF_FFFE, 1'b0, 1'b0);
      rd(1'b0, 1'b0);
      step(1'b1, 1'b0, RA ^ 8'h80, '0, 1'b0, 1'b0);
      wr(RA, 32'h1, 1'b0, 1'b0);
      step(1'b1, 1'b0, RA + 8'd2, '0, 1'b0, 1'b0);  // other address reads 0
      rd(1'b0, 1'b0);

      // Random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [ADDR_W-1:0] a;
         a = ($urandom % 2) ? RA : ADDR_W'($urandom);
         step(1'($urandom), 1'($urandom), a, $urandom,
              ($urandom % 4) != 0, ($urandom % 4) != 0);
      end
      step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
      step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule